// File: doc/BRIEF.md
# SHA-1 Message Padder

This block sits in front of a SHA-1 compression engine. A message enters one byte per beat on a valid/ready stream, and a flag marks the final beat. The block packs the bytes into 512-bit blocks. It appends a single one bit and then zero fill. The last block of the message ends with the message length in bits, stored as a 64-bit field. Each block leaves on a valid/ready handshake, and a flag marks the final block of the message.

The bit count is kept on the fly, so there is no message-length input. The trailer needs 9 spare bytes: one pad byte plus the 8-byte length. When the last block has fewer than 9 spare bytes, the block emits one more block to hold the rest of the padding.

A message with no bytes is sent as a single beat that has both the last flag and the no-byte flag set. Byte input stops while a finished block waits for the consumer.

Top module: `sha1_msg_padder`

## Requirements
- R1: Message bytes are packed big-endian. Byte k of a block (k = 0..63) sits at bits 511-8k down to 504-8k, so the first message byte lands in bits 511:504.
- R2: Byte value 0x80 is placed directly after the last message byte. Every byte between it and the length field is zero.
- R3: Bits 63:0 of the final block hold the message length in bits, most significant byte first. The length wraps modulo 2^64.
- R4: A message whose last block holds 0 to 55 message bytes ends in that block. That block carries the 0x80 byte and the length, and it is flagged final.
- R5: A message whose last block holds 56 to 63 message bytes produces one extra final block. The earlier block is not flagged final, and the extra block is all zero except the length.
- R6: A non-empty message whose length is a multiple of 64 bytes produces one extra final block. That block starts with 0x80 in byte 0 and ends with the length.
- R7: A beat with in_nobyte set contributes no byte. A message made of a single such beat with in_last set produces exactly one block: 0x80, zeros, and a length of zero.
- R8: out_final is set only on the last block of each message, and no block is emitted beyond the padded length.
- R9: in_ready is low in every cycle in which out_valid is high.
- R10: While out_valid is high and out_ready is low, out_block and out_final hold their values.
- R11: The length count restarts at zero after the final block of a message is accepted, so back-to-back messages are padded independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with in_valid |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat is the last of the message |
| in_nobyte | input | 1 | Beat carries no byte (used for the empty message) |
| out_valid | output | 1 | Padded block available |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 512 | Padded block, byte 0 in bits 511:504 |
| out_final | output | 1 | Block is the last of the message |

## Verification
Two cases can fall on the same beat.

The first is a full block and the end of the message together: the byte that fills position 63 is also the last byte. The block must then leave unflagged, followed by a block that begins with 0x80. Lengths of 64 and 128 bytes provoke this case, and the bench judges it by comparing the whole block sequence against a padded image it builds itself.

The second is the consumer stalling while a block is held and the sender still has bytes to offer. The bench throttles out_ready in several patterns. Each cycle it checks that in_ready stays low and that the held block and flag do not change.

// File: rtl/sha1_msg_padder.sv
module sha1_msg_padder #(
  parameter int BLK_BYTES = 64,
  parameter int LEN_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  input  logic                   in_nobyte,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [BLK_BYTES*8-1:0] out_block,
  output logic                   out_final
);
  localparam int BLK_W  = BLK_BYTES * 8;
  localparam int LEN_W  = LEN_BYTES * 8;
  localparam int POS_W  = $clog2(BLK_BYTES) + 1;
  localparam int IDX_W  = $clog2(BLK_BYTES);
  localparam logic [POS_W-1:0] POS_FULL = POS_W'(BLK_BYTES);
  localparam logic [POS_W-1:0] POS_FIT  = POS_W'(BLK_BYTES - LEN_BYTES - 1);

  typedef enum logic [1:0] {ST_FILL, ST_PAD, ST_LEN, ST_OUT} st_t;
  typedef enum logic [1:0] {NX_FILL, NX_MARK, NX_LEN} nx_t;

  st_t              st;
  nx_t              nx;
  logic [BLK_W-1:0] blk;
  logic [POS_W-1:0] pos;
  logic [LEN_W-1:0] bitcnt;
  logic             fin;

  logic [POS_W-1:0]    pos_nx;
  logic [IDX_W-1:0]    slot;
  logic [IDX_W+2:0]    lsb;
  logic                take;

  assign in_ready  = (st == ST_FILL);
  assign out_valid = (st == ST_OUT);
  assign out_block = blk;
  assign out_final = fin;
  assign take      = in_valid && in_ready;
  assign pos_nx    = pos + (in_nobyte ? POS_W'(0) : POS_W'(1));
  assign slot      = ~pos[IDX_W-1:0];
  assign lsb       = {slot, 3'b000};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FILL;
      nx     <= NX_FILL;
      blk    <= '0;
      pos    <= '0;
      bitcnt <= '0;
      fin    <= 1'b0;
    end else begin
      case (st)
        ST_FILL: if (take) begin
          if (!in_nobyte) begin
            blk[lsb +: 8] <= in_data;
            bitcnt        <= bitcnt + LEN_W'(8);
          end
          pos <= pos_nx;
          if (in_last) st <= ST_PAD;
          else if (pos_nx == POS_FULL) begin
            st  <= ST_OUT;
            fin <= 1'b0;
            nx  <= NX_FILL;
          end
        end
        ST_PAD: begin
          st <= ST_OUT;
          if (pos == POS_FULL) begin
            fin <= 1'b0;
            nx  <= NX_MARK;
          end else begin
            blk[lsb +: 8] <= 8'h80;
            if (pos <= POS_FIT) begin
              blk[LEN_W-1:0] <= bitcnt;
              fin            <= 1'b1;
              nx             <= NX_FILL;
            end else begin
              fin <= 1'b0;
              nx  <= NX_LEN;
            end
          end
        end
        ST_LEN: begin
          blk[LEN_W-1:0] <= bitcnt;
          fin            <= 1'b1;
          nx             <= NX_FILL;
          st             <= ST_OUT;
        end
        default: if (out_ready) begin
          blk <= '0;
          pos <= '0;
          if (fin) begin
            bitcnt <= '0;
            st     <= ST_FILL;
          end else begin
            case (nx)
              NX_MARK: st <= ST_PAD;
              NX_LEN:  st <= ST_LEN;
              default: st <= ST_FILL;
            endcase
          end
        end
      endcase
    end
  end

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_HOLD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_block) && $stable(out_final)); // R10
  AST_FINAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_final |-> out_block[LEN_W-1:0] == bitcnt); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_nobyte |=> bitcnt == $past(bitcnt) + LEN_W'(8)); // R3
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_final |=> bitcnt == '0 && in_ready); // R11
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_FULL); // R1
endmodule

// File: tb/sha1_msg_padder_bench.sv
module sha1_msg_padder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_data = '0;
  logic         in_last = 1'b0;
  logic         in_nobyte = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [511:0] out_block;
  logic         out_final;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int stall = 0;
  int got = 0;
  int nexp = 0;
  int r9_bad = 0;
  int r10_bad = 0;
  bit finished = 0;
  string cur_tag = "R1";

  logic [7:0]   msg [0:255];
  logic [7:0]   pb  [0:319];
  logic [511:0] exp_blk [0:4];
  bit           exp_fin [0:4];

  sha1_msg_padder u_sha1_msg_padder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_nobyte(in_nobyte),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
    .out_final(out_final));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  initial begin : collector
    logic [511:0] hb;
    bit hf;
    bit hold;
    hold = 0;
    hb = '0;
    hf = 0;
    forever begin
      @(negedge clk);
      cyc++;
      case (stall)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 5) == 0;
      endcase
      if (out_valid && in_ready) r9_bad++;
      if (hold && !(out_valid && out_block == hb && out_final == hf)) r10_bad++;
      if (out_valid && out_ready) begin
        if (got < nexp) begin
          check(out_block == exp_blk[got], cur_tag,
                $sformatf("block %0d got %h exp %h", got, out_block, exp_blk[got]));
          check(out_final == exp_fin[got], "R8",
                $sformatf("final flag block %0d got %0b exp %0b", got, out_final, exp_fin[got]));
        end else begin
          check(1'b0, "R8", $sformatf("extra block got %h exp none", out_block));
        end
        got++;
      end
      hold = out_valid && !out_ready;
      hb = out_block;
      hf = out_final;
    end
  end

  task automatic build_expected(input int len);
    int total;
    logic [63:0] bits;
    for (int i = 0; i < 320; i++) pb[i] = 8'h00;
    for (int i = 0; i < len; i++) pb[i] = msg[i];
    pb[len] = 8'h80;
    total = ((len + 8) / 64 + 1) * 64;
    bits = 64'(len) * 64'd8;
    for (int k = 0; k < 8; k++) pb[total - 8 + k] = bits[63 - 8*k -: 8];
    nexp = total / 64;
    for (int b = 0; b < nexp; b++) begin
      for (int k = 0; k < 64; k++) exp_blk[b][511 - 8*k -: 8] = pb[b*64 + k];
      exp_fin[b] = (b == nexp - 1);
    end
  endtask

  task automatic run_msg(input int len, input int seed, input int mode, input string tag);
    stall = mode;
    cur_tag = tag;
    for (int i = 0; i < len; i++) msg[i] = 8'(seed + i * 37);
    build_expected(len);
    got = 0;
    r9_bad = 0;
    r10_bad = 0;
    @(negedge clk);
    if (len == 0) begin
      in_valid = 1'b1; in_last = 1'b1; in_nobyte = 1'b1; in_data = 8'hA5;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end else begin
      for (int i = 0; i < len; i++) begin
        in_valid = 1'b1; in_data = msg[i]; in_last = (i == len - 1); in_nobyte = 1'b0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_last = 1'b0; in_nobyte = 1'b0;
    while (got < nexp) @(negedge clk);
    repeat (6) @(negedge clk);
    check(got == nexp, "R8", $sformatf("len %0d block count got %0d exp %0d", len, got, nexp));
    check(r9_bad == 0, "R9", $sformatf("len %0d ready-while-valid cycles got %0d exp 0", len, r9_bad));
    check(r10_bad == 0, "R10", $sformatf("len %0d unstable held cycles got %0d exp 0", len, r10_bad));
  endtask

  task automatic test_reset;
    @(negedge clk);
    check(in_ready == 1'b1, "R9", $sformatf("reset in_ready got %0b exp 1", in_ready));
    check(out_valid == 1'b0, "R8", $sformatf("reset out_valid got %0b exp 0", out_valid));
  endtask

  task automatic test_abc;
    logic [511:0] e;
    stall = 0;
    cur_tag = "R1";
    msg[0] = 8'h61; msg[1] = 8'h62; msg[2] = 8'h63;
    build_expected(3);
    e = '0;
    e[511:480] = 32'h61626380;
    e[63:0] = 64'd24;
    check(exp_blk[0] == e, "R3", "abc expected image mismatch");
    got = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = msg[i]; in_last = (i == 2); in_nobyte = 1'b0;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    while (got < nexp) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_abc();
    run_msg(0,   11, 0, "R7");
    run_msg(1,   3,  1, "R2");
    run_msg(55,  5,  0, "R4");
    run_msg(56,  7,  1, "R5");
    run_msg(63,  9,  2, "R5");
    run_msg(64,  13, 0, "R6");
    run_msg(65,  17, 2, "R1");
    run_msg(119, 19, 1, "R4");
    run_msg(120, 23, 0, "R5");
    run_msg(128, 29, 1, "R6");
    run_msg(200, 31, 2, "R11");
    run_msg(0,   41, 1, "R11");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule